// File: doc/BRIEF.md
# Nonvolatile Configuration Bit Controller

The controller keeps an array of configuration bits that survive power loss (64 by default) and lets software change or inspect them through four word-addressed registers: mode, command, status and result. A command word carries a protection key, an argument and an operation code. Three operations exist: assert one bit, deassert one bit, and capture the whole array for readback. Every command is checked against the key, the operation code and, for single-bit operations, the index range before anything happens.

Single-bit operations are passed to an external program/verify sequencer over a request/acknowledge handshake. The sequencer answers with a pass or fail indication once its verify loop is finished. The capture operation copies the array into a result buffer. Successive reads of the result register then stream the captured bits out 32 at a time, and once the array is used up they return zero. A ready flag in the status register reports completion. A level interrupt follows that flag when the mode register enables it.

Top module: `nvcfg_ctrl`

## Requirements
- R1: After reset the status register reads 0x1 (ready=1, both error flags 0), `irq_o` and `prog_req_o` are low, every configuration bit is 0 and the result register reads zero.
- R2: A command word with key 0x5A in bits 31:24, operation 0x0B in bits 7:0 and an index below NBITS in bits 23:8 clears ready. It raises `prog_req_o` with `prog_set_o`=1 and `prog_idx_o` equal to the index. When `prog_ack_i` arrives with `prog_fail_i`=0, the bit becomes 1 and ready returns to 1.
- R3: Operation 0x0C behaves as R2 but with `prog_set_o`=0, and on a passing acknowledge the bit becomes 0.
- R4: Operation 0x0D ignores bits 23:8 and completes two cycles after the write without a sequencer request. The next result read returns bits 31:0 of the array, with word bit n equal to configuration bit n, and each later read returns the next 32 bits.
- R5: Result reads beyond the last word of the array return 0, and a new capture restarts the stream at bit 0.
- R6: A command whose key is not 0x5A sets the command-error flag (status bit 1). It leaves ready at 1, makes no sequencer request and changes no bit.
- R7: An unknown operation code, or a single-bit operation with an index of NBITS or more, sets the command-error flag and changes no bit.
- R8: An acknowledge with `prog_fail_i`=1 sets the flash-error flag (status bit 2), leaves the bit unchanged and returns ready to 1.
- R9: Ready (status bit 0) stays low while an operation is in progress, and command writes made in that time are ignored: they change no bit and raise no flag.
- R10: `irq_o` equals ready AND bit 0 of the mode register (enable), so it stays low while that bit is 0.
- R11: A status read returns the current flags and then clears both error flags. The status register's ready bit is not affected by the read.
- R12: Once raised, `prog_req_o` stays high with a stable index until the cycle in which `prog_ack_i` is seen, and drops the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register select: 0 mode, 1 command, 2 status, 3 result |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read strobe |
| irq_o | output | 1 | Completion interrupt (level) |
| prog_req_o | output | 1 | Request to the program/verify sequencer |
| prog_set_o | output | 1 | 1 = program bit to 1, 0 = program bit to 0 |
| prog_idx_o | output | IDX_W (6) | Bit index for the sequencer |
| prog_ack_i | input | 1 | Sequencer has finished |
| prog_fail_i | input | 1 | Verify failed after the last pulse; valid with ack |

## Verification
The hardest state to reach from the ports is a command write that arrives while a single-bit operation is still waiting on the sequencer. To get there, the bench models the sequencer itself and holds back the acknowledge for a random number of cycles, so a second write can be placed inside that window. A second awkward case is a flash error raised when a command error is already pending. The random mix reaches it by injecting failing acknowledges and bad keys without a status read between them, so flags pile up before they are checked and cleared.

// File: rtl/nvcfg_pkg.sv
package nvcfg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [7:0]  CMD_KEY = 8'h5A;
  localparam logic [7:0]  OP_SET  = 8'h0B;
  localparam logic [7:0]  OP_CLR  = 8'h0C;
  localparam logic [7:0]  OP_GET  = 8'h0D;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_RES  = 2'd3;

  typedef enum logic [1:0] {K_SET, K_CLR, K_GET, K_BAD} cmd_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PROG, ST_GET} ctrl_state_e;
endpackage

// File: rtl/nvcfg_cmd_decode.sv
module nvcfg_cmd_decode
  import nvcfg_pkg::*;
#(
  parameter int unsigned NBITS = 64,
  localparam int unsigned IW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic [31:0]   cmd_i,
  output cmd_kind_e     kind_o,
  output logic [IW-1:0] idx_o
);
  logic [7:0]  key;
  logic [7:0]  op;
  logic [15:0] arg;
  logic        in_range;

  assign key      = cmd_i[31:24];
  assign arg      = cmd_i[23:8];
  assign op       = cmd_i[7:0];
  assign in_range = ({16'b0, arg} < 32'(NBITS));
  assign idx_o    = arg[IW-1:0];

  always_comb begin
    kind_o = K_BAD;
    if (key == CMD_KEY) begin
      unique case (op)
        OP_SET:  kind_o = in_range ? K_SET : K_BAD;
        OP_CLR:  kind_o = in_range ? K_CLR : K_BAD;
        OP_GET:  kind_o = K_GET;
        default: kind_o = K_BAD;
      endcase
    end
  end

  always_comb begin
    if (kind_o == K_SET || kind_o == K_CLR)
      assert_idx_range_R7: assert ({16'b0, arg} < 32'(NBITS));
  end
endmodule

// File: rtl/nvcfg_bit_array.sv
module nvcfg_bit_array #(
  parameter int unsigned NBITS = 64,
  localparam int unsigned IW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_val_i,
  input  logic [IW-1:0]    wr_idx_i,
  output logic [NBITS-1:0] bits_o
);
  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            bits_o[b] <= 1'b0;
      else if (wr_en_i && wr_idx_i == IW'(b)) bits_o[b] <= wr_val_i;
    end
  end

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(bits_o));
  assert_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> bits_o[$past(wr_idx_i)] == $past(wr_val_i));
  assert_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> $countones(bits_o ^ $past(bits_o)) <= 1);
endmodule

// File: rtl/nvcfg_result_port.sv
module nvcfg_result_port #(
  parameter int unsigned NBITS = 64,
  localparam int unsigned NWORDS = (NBITS + 31) / 32,
  localparam int unsigned PADW = NWORDS * 32,
  localparam int unsigned PW = $clog2(NWORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             rd_i,
  input  logic [NBITS-1:0] bits_i,
  output logic [31:0]      word_o
);
  logic [PADW-1:0] pad;
  logic [PADW-1:0] snap_q;
  logic [PW-1:0]   ptr_q;

  always_comb begin
    pad = '0;
    pad[NBITS-1:0] = bits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      ptr_q  <= '0;
    end else if (capture_i) begin
      snap_q <= pad;
      ptr_q  <= '0;
    end else if (rd_i && ptr_q < PW'(NWORDS)) begin
      ptr_q  <= ptr_q + 1'b1;
    end
  end

  always_comb begin
    word_o = '0;
    for (int w = 0; w < NWORDS; w++)
      if (ptr_q == PW'(w)) word_o = snap_q[w*32 +: 32];
  end

  assert_tail_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ptr_q >= PW'(NWORDS)) |-> word_o == '0);
  assert_ptr_sat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> ptr_q <= PW'(NWORDS));
  assert_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> ptr_q == '0);
endmodule

// File: rtl/nvcfg_ctrl.sv
module nvcfg_ctrl
  import nvcfg_pkg::*;
#(
  parameter int unsigned NBITS = 64,
  localparam int unsigned IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             irq_o,
  output logic             prog_req_o,
  output logic             prog_set_o,
  output logic [IDX_W-1:0] prog_idx_o,
  input  logic             prog_ack_i,
  input  logic             prog_fail_i
);
  ctrl_state_e      state_q;
  cmd_kind_e        kind;
  logic [IDX_W-1:0] dec_idx;
  logic [NBITS-1:0] bits;
  logic [31:0]      res_word;
  logic             ready_q, cmd_err_q, flash_err_q, irq_en_q;
  logic             set_q;
  logic [IDX_W-1:0] idx_q;
  logic             rd_en, cmd_wr, stat_rd, res_rd, idle, accept, prog_done;

  assign rd_en     = req_i && !we_i;
  assign cmd_wr    = req_i && we_i && addr_i == A_CMD;
  assign stat_rd   = rd_en && addr_i == A_STAT;
  assign res_rd    = rd_en && addr_i == A_RES;
  assign idle      = state_q == ST_IDLE;
  assign accept    = cmd_wr && idle && kind != K_BAD;
  assign prog_done = state_q == ST_PROG && prog_ack_i;

  nvcfg_cmd_decode #(.NBITS(NBITS)) u_dec (
    .cmd_i (wdata_i),
    .kind_o(kind),
    .idx_o (dec_idx)
  );

  nvcfg_bit_array #(.NBITS(NBITS)) u_bits (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (prog_done && !prog_fail_i),
    .wr_val_i(set_q),
    .wr_idx_i(idx_q),
    .bits_o  (bits)
  );

  nvcfg_result_port #(.NBITS(NBITS)) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(state_q == ST_GET),
    .rd_i     (res_rd),
    .bits_i   (bits),
    .word_o   (res_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b1;
      set_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          ready_q <= 1'b0;
          set_q   <= kind == K_SET;
          idx_q   <= dec_idx;
          state_q <= (kind == K_GET) ? ST_GET : ST_PROG;
        end
        ST_PROG: if (prog_ack_i) begin
          ready_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_GET: begin
          ready_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // flag set wins over the clear-on-read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_err_q   <= 1'b0;
      flash_err_q <= 1'b0;
      irq_en_q    <= 1'b0;
    end else begin
      if (cmd_wr && idle && kind == K_BAD) cmd_err_q <= 1'b1;
      else if (stat_rd)                    cmd_err_q <= 1'b0;
      if (prog_done && prog_fail_i)        flash_err_q <= 1'b1;
      else if (stat_rd)                    flash_err_q <= 1'b0;
      if (req_i && we_i && addr_i == A_MODE) irq_en_q <= wdata_i[0];
    end
  end

  always_comb begin
    unique case (addr_i)
      A_MODE:  rdata_o = {31'b0, irq_en_q};
      A_STAT:  rdata_o = {29'b0, flash_err_q, cmd_err_q, ready_q};
      A_RES:   rdata_o = res_word;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o      = ready_q && irq_en_q;
  assign prog_req_o = state_q == ST_PROG;
  assign prog_set_o = set_q;
  assign prog_idx_o = idx_q;

  assert_busy_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle |-> !ready_q);
  assert_busy_write_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !idle && !stat_rd) |=> $stable(cmd_err_q));
  assert_req_held_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o && !prog_ack_i) |=> prog_req_o && $stable(prog_idx_o));
  assert_req_drop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o && prog_ack_i) |=> !prog_req_o);
  assert_badkey_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && idle && wdata_i[31:24] != CMD_KEY) |=> cmd_err_q && ready_q && !prog_req_o);
  assert_fail_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_done && prog_fail_i) |=> flash_err_q && ready_q);
  assert_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_q |-> !irq_o);
endmodule

// File: tb/nvcfg_ctrl_tb.sv
module nvcfg_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, prog_req, prog_set, ack = 1'b0, fail = 1'b0;
  logic [5:0]  prog_idx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [NB-1:0] exp_bits = '0;
  logic exp_ready = 1'b1, exp_cmd = 1'b0, exp_flash = 1'b0, exp_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvcfg_ctrl #(.NBITS(NB)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .prog_req_o(prog_req),
    .prog_set_o(prog_set), .prog_idx_o(prog_idx), .prog_ack_i(ack), .prog_fail_i(fail)
  );

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  function automatic logic [31:0] exp_word(input int w);
    if (w * 32 >= NB) return '0;
    return exp_bits[w*32 +: 32];
  endfunction

  task automatic chk_status(input string r);
    logic [31:0] d;
    bus_rd(2'd2, d);
    check(r, d, {29'b0, exp_flash, exp_cmd, exp_ready});
    exp_cmd = 0; exp_flash = 0;
  endtask

  task automatic chk_irq(input string r);
    check(r, irq, exp_ready & exp_en);
  endtask

  // issue a command and play the sequencer side
  task automatic do_cmd(input logic [7:0] key, input logic [7:0] op, input logic [15:0] arg,
                        input bit vfail, input int lat, input bit poke);
    bit ok;
    logic [31:0] d;
    ok = key == 8'h5A && (op == 8'h0D || ((op == 8'h0B || op == 8'h0C) && arg < 16'(NB)));
    bus_wr(2'd1, {key, arg, op});
    if (!ok) begin
      exp_cmd = 1;
      check("R6/R7 no request on rejected command", prog_req, 1'b0);
    end else if (op == 8'h0D) begin
      check("R4 get makes no request", prog_req, 1'b0);
      @(negedge clk);
    end else begin
      check("R2/R3 request raised", prog_req, 1'b1);
      check("R2/R3 direction", prog_set, op == 8'h0B);
      check("R2/R3 index", prog_idx, arg[5:0]);
      exp_ready = 0;
      chk_irq("R10 irq low while busy");
      if (poke) begin
        bus_wr(2'd1, {8'h5A, 16'((arg + 1) % NB), (op == 8'h0B) ? 8'h0C : 8'h0B});
        bus_rd(2'd2, d);
        check("R9 ready low while busy", d[0], 1'b0);
        check("R9 busy write raises no flag", d[1], exp_cmd);
        exp_cmd = 0; exp_flash = 0;
      end
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        check("R12 request held", {prog_req, prog_idx}, {1'b1, arg[5:0]});
      end
      ack = 1; fail = vfail;
      @(negedge clk); ack = 0; fail = 0;
      check("R12 request dropped after ack", prog_req, 1'b0);
      exp_ready = 1;
      if (vfail) exp_flash = 1;
      else exp_bits[arg[5:0]] = (op == 8'h0B);
    end
    chk_irq("R10 irq after command");
  endtask

  task automatic chk_get(input string r);
    logic [31:0] d;
    do_cmd(8'h5A, 8'h0D, 16'($urandom), 0, 0, 0);
    for (int w = 0; w < 4; w++) begin
      bus_rd(2'd3, d);
      check(r, d, exp_word(w));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    check("R1 irq at reset", irq, 1'b0);
    check("R1 no request at reset", prog_req, 1'b0);
    chk_status("R1 status at reset");
    bus_rd(2'd3, d);
    check("R1 result empty at reset", d, 32'h0);
    chk_get("R1 bits zero at reset");

    // directed
    do_cmd(8'h5A, 8'h0B, 16'd0, 0, 0, 0);  chk_status("R2 set bit 0");
    do_cmd(8'h5A, 8'h0B, 16'd63, 0, 2, 0); chk_status("R2 set top bit");
    do_cmd(8'h5A, 8'h0B, 16'd33, 0, 1, 0);
    chk_get("R4 readback after sets");
    do_cmd(8'h5A, 8'h0C, 16'd0, 0, 1, 0);  chk_status("R3 clear bit 0");
    do_cmd(8'h5A, 8'h0B, 16'd5, 1, 3, 0);  chk_status("R8 flash error");
    chk_get("R8 failed write leaves bit");
    do_cmd(8'hA5, 8'h0B, 16'd7, 0, 0, 0);  chk_status("R6 bad key");
    chk_status("R11 flags cleared by read");
    do_cmd(8'h5A, 8'h0B, 16'd64, 0, 0, 0); chk_status("R7 index out of range");
    do_cmd(8'h5A, 8'h77, 16'd3, 0, 0, 0);  chk_status("R7 unknown code");
    chk_get("R7 rejected commands change no bit");
    do_cmd(8'h5A, 8'h0B, 16'd10, 0, 2, 1); chk_status("R9 busy write ignored");
    chk_get("R9 readback after busy write");
    // errors pile up, one read reports and clears both
    do_cmd(8'h00, 8'h0B, 16'd1, 0, 0, 0);
    do_cmd(8'h5A, 8'h0C, 16'd10, 1, 0, 0);
    chk_status("R11 both flags reported");
    chk_status("R11 both flags cleared");
    bus_wr(2'd0, 32'h1); exp_en = 1;
    #1 chk_irq("R10 irq when enabled and ready");
    bus_rd(2'd0, d);
    check("R10 mode enable readback", d, 32'h1);
    // R5 partial restart of the stream
    do_cmd(8'h5A, 8'h0D, 16'hFFFF, 0, 0, 0);
    bus_rd(2'd3, d); check("R5 first word", d, exp_word(0));
    chk_get("R5 restart after new get");

    // random mix
    for (int it = 0; it < 150; it++) begin
      int sel;
      logic [7:0] key, op;
      logic [15:0] arg;
      sel = int'($urandom % 100);
      key = ($urandom % 10 == 0) ? 8'(($urandom % 255) + 1) ^ 8'h5A : 8'h5A;
      arg = 16'($urandom % 72);
      op  = (sel < 40) ? 8'h0B : (sel < 70) ? 8'h0C : (sel < 85) ? 8'h0D : 8'h33;
      if (op == 8'h0D && key == 8'h5A) chk_get("R4 random readback");
      else do_cmd(key, op, arg, ($urandom % 8) == 0, int'($urandom % 4), ($urandom % 6) == 0);
      if ($urandom % 3 == 0) chk_status("R2/R3/R6/R7/R8 random status");
      if ($urandom % 20 == 0) begin
        exp_en = ~exp_en; bus_wr(2'd0, {31'b0, exp_en});
        #1 chk_irq("R10 random enable");
      end
    end
    chk_status("R11 final status");
    chk_get("R5 final readback");
    finish_run();
  end
endmodule